// File: doc/BRIEF.md
# Load/Store Address Steering Bridge

This block sits between the load/store port of a single-cycle CPU and two kinds of target: the data RAM, and a small set of board peripherals at the top of the byte address space. It looks at the byte address of each access. Any address below the I/O window goes to the RAM. An address inside the window selects one peripheral. The block drives the RAM write enable, a write strobe for each output device, and the 32-bit load data that returns to write-back.

The peripherals are two 8-bit LED banks (right and left, 16 LEDs in all), two 8-bit switch banks, a one-bit enter button, and a 32-bit value register for the seven-segment display. Software reads the switches and the button by polling. No interrupt is raised. An access is complete in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. The port accepts one access every cycle. Load data is combinational in the same cycle, and a store takes effect on the next rising edge.

Top module: `mmio_bridge`

## Requirements
- R1: `ram_we` is 1 exactly when `cpu_store` is 1 and `cpu_addr` is below 0xFFFFFC00. A store to any address at or above 0xFFFFFC00 never writes RAM.
- R2: A store to 0xFFFFFC60 pulses `led_wr_right` in the same cycle, and `led_right` takes `cpu_wdata[7:0]` at the next rising edge.
- R3: A store to 0xFFFFFC62 pulses `led_wr_left` in the same cycle, and `led_left` takes `cpu_wdata[7:0]` at the next rising edge.
- R4: A store to 0xFFFFFC80 pulses `seg_wr` in the same cycle, and `seg_value` takes all 32 bits of `cpu_wdata` at the next rising edge.
- R5: A load from an address below 0xFFFFFC00 returns `ram_rdata` unchanged on `cpu_rdata` in the same cycle.
- R6: A load from 0xFFFFFC70 returns `sw_right`, and a load from 0xFFFFFC72 returns `sw_left`. In both cases bits 31:8 are zero.
- R7: A load from 0xFFFFFC73 returns the button level in bit 0, with bits 31:1 zero.
- R8: A load from any other address at or above 0xFFFFFC00, including the LED and segment addresses, returns zero. `cpu_rdata` is zero whenever `cpu_load` is 0.
- R9: While `rst_n` is low, `led_right`, `led_left` and `seg_value` are zero. After reset they change only on the edge that ends a store to their own address. Loads, RAM stores and stores to other I/O addresses leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_store | input | 1 | Access is a store |
| cpu_load | input | 1 | Access is a load |
| cpu_rdata | output | 32 | Load result to write-back |
| ram_rdata | input | 32 | Read data from the data RAM |
| ram_we | output | 1 | Data RAM write enable |
| sw_right | input | 8 | Right switch bank |
| sw_left | input | 8 | Left switch bank |
| btn_enter | input | 1 | Enter button level |
| led_wr_right | output | 1 | Right LED bank write strobe |
| led_wr_left | output | 1 | Left LED bank write strobe |
| seg_wr | output | 1 | Segment value write strobe |
| led_right | output | 8 | Right LED bank value |
| led_left | output | 8 | Left LED bank value |
| seg_value | output | 32 | Seven-segment display value |

## Verification
A decode error shows up at the ports in the same cycle. The wrong device sees a strobe, `ram_we` flips for an I/O or RAM store, or `cpu_rdata` carries the wrong source. A wrong latched value in an LED or segment register shows one edge after the store that caused it. It stays visible on the output pins until the next qualifying store, so the bench compares every register output on every cycle. The address boundaries 0xFFFFFBFF and 0xFFFFFC00, and the byte next to each device address, are driven on purpose. This catches a decode that is off by one or that masks low address bits.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [2:0] {
    DEV_RAM   = 3'd0,
    DEV_LED_R = 3'd1,
    DEV_LED_L = 3'd2,
    DEV_SW_R  = 3'd3,
    DEV_SW_L  = 3'd4,
    DEV_BTN   = 3'd5,
    DEV_SEG   = 3'd6,
    DEV_NONE  = 3'd7
  } dev_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] IO_BASE  = 32'hFFFF_FC00,
  parameter logic [31:0] A_LED_R  = 32'hFFFF_FC60,
  parameter logic [31:0] A_LED_L  = 32'hFFFF_FC62,
  parameter logic [31:0] A_SW_R   = 32'hFFFF_FC70,
  parameter logic [31:0] A_SW_L   = 32'hFFFF_FC72,
  parameter logic [31:0] A_BTN    = 32'hFFFF_FC73,
  parameter logic [31:0] A_SEG    = 32'hFFFF_FC80
) (
  input  logic [ADDR_W-1:0] addr,
  output dev_e              dev
);
  always_comb begin
    if (addr < IO_BASE[ADDR_W-1:0])           dev = DEV_RAM;
    else if (addr == A_LED_R[ADDR_W-1:0])     dev = DEV_LED_R;
    else if (addr == A_LED_L[ADDR_W-1:0])     dev = DEV_LED_L;
    else if (addr == A_SW_R[ADDR_W-1:0])      dev = DEV_SW_R;
    else if (addr == A_SW_L[ADDR_W-1:0])      dev = DEV_SW_L;
    else if (addr == A_BTN[ADDR_W-1:0])       dev = DEV_BTN;
    else if (addr == A_SEG[ADDR_W-1:0])       dev = DEV_SEG;
    else                                      dev = DEV_NONE;
  end
endmodule

// File: rtl/mmio_wreg.sv
module mmio_wreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/mmio_rdmux.sv
module mmio_rdmux
  import mmio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK_W = 8
) (
  input  logic              load,
  input  dev_e              dev,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [BANK_W-1:0] sw_right,
  input  logic [BANK_W-1:0] sw_left,
  input  logic              btn,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (load) begin
      unique case (dev)
        DEV_RAM:  rdata = ram_rdata;
        DEV_SW_R: rdata[BANK_W-1:0] = sw_right;
        DEV_SW_L: rdata[BANK_W-1:0] = sw_left;
        DEV_BTN:  rdata[0] = btn;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
  import mmio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_store,
  input  logic              cpu_load,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  input  logic [BANK_W-1:0] sw_right,
  input  logic [BANK_W-1:0] sw_left,
  input  logic              btn_enter,
  output logic              led_wr_right,
  output logic              led_wr_left,
  output logic              seg_wr,
  output logic [BANK_W-1:0] led_right,
  output logic [BANK_W-1:0] led_left,
  output logic [DATA_W-1:0] seg_value
);
  dev_e dev;

  mmio_decode #(.ADDR_W(32)) u_dec (
    .addr (cpu_addr),
    .dev  (dev)
  );

  assign ram_we       = cpu_store && (dev == DEV_RAM);
  assign led_wr_right = cpu_store && (dev == DEV_LED_R);
  assign led_wr_left  = cpu_store && (dev == DEV_LED_L);
  assign seg_wr       = cpu_store && (dev == DEV_SEG);

  mmio_wreg #(.W(BANK_W)) u_led_r (
    .clk (clk), .rst_n (rst_n), .we (led_wr_right),
    .d (cpu_wdata[BANK_W-1:0]), .q (led_right)
  );

  mmio_wreg #(.W(BANK_W)) u_led_l (
    .clk (clk), .rst_n (rst_n), .we (led_wr_left),
    .d (cpu_wdata[BANK_W-1:0]), .q (led_left)
  );

  mmio_wreg #(.W(DATA_W)) u_seg (
    .clk (clk), .rst_n (rst_n), .we (seg_wr),
    .d (cpu_wdata), .q (seg_value)
  );

  mmio_rdmux #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_rd (
    .load      (cpu_load),
    .dev       (dev),
    .ram_rdata (ram_rdata),
    .sw_right  (sw_right),
    .sw_left   (sw_left),
    .btn       (btn_enter),
    .rdata     (cpu_rdata)
  );
endmodule

// File: rtl/mmio_bridge_chk.sv
module mmio_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int BANK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_store,
  input logic              cpu_load,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              ram_we,
  input logic              led_wr_right,
  input logic              led_wr_left,
  input logic              seg_wr,
  input logic [BANK_W-1:0] led_right,
  input logic [BANK_W-1:0] led_left,
  input logic [DATA_W-1:0] seg_value
);
  localparam logic [31:0] IO_LO = 32'hFFFF_FC00;

  // R1: RAM write only for stores below the window
  assert_ram_we_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_store && cpu_addr < IO_LO));
  assert_io_no_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_store && cpu_addr >= IO_LO) |-> !ram_we);
  // R2, R3: LED banks capture store data
  assert_led_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
    led_wr_right |=> led_right == $past(cpu_wdata[BANK_W-1:0]));
  assert_led_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
    led_wr_left |=> led_left == $past(cpu_wdata[BANK_W-1:0]));
  // R4: segment value captures store data
  assert_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr |=> seg_value == $past(cpu_wdata));
  // Strobes are mutually exclusive (R2, R3, R4)
  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, led_wr_right, led_wr_left, seg_wr}));
  // R8: no load, no data
  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_load |-> cpu_rdata == '0);
  // R9: registers hold without a strobe, zero in reset
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_wr_right || led_wr_left || seg_wr) |=>
      ($stable(led_right) && $stable(led_left) && $stable(seg_value)));
  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |-> (led_right == '0 && led_left == '0 && seg_value == '0));
endmodule

bind mmio_bridge mmio_bridge_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
  .cpu_store (cpu_store), .cpu_load (cpu_load), .cpu_rdata (cpu_rdata),
  .ram_we (ram_we), .led_wr_right (led_wr_right), .led_wr_left (led_wr_left),
  .seg_wr (seg_wr), .led_right (led_right), .led_left (led_left),
  .seg_value (seg_value)
);

// File: tb/tb_mmio_bridge.sv
module tb_mmio_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, ram_rdata = '0;
  logic        cpu_store = 1'b0, cpu_load = 1'b0;
  logic [7:0]  sw_right = '0, sw_left = '0;
  logic        btn_enter = 1'b0;
  logic [31:0] cpu_rdata, seg_value;
  logic        ram_we, led_wr_right, led_wr_left, seg_wr;
  logic [7:0]  led_right, led_left;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0]  m_ledr = '0, m_ledl = '0;
  logic [31:0] m_seg = '0;

  always #2 clk = ~clk;

  mmio_bridge dut (
    .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_store (cpu_store), .cpu_load (cpu_load), .cpu_rdata (cpu_rdata),
    .ram_rdata (ram_rdata), .ram_we (ram_we), .sw_right (sw_right),
    .sw_left (sw_left), .btn_enter (btn_enter), .led_wr_right (led_wr_right),
    .led_wr_left (led_wr_left), .seg_wr (seg_wr), .led_right (led_right),
    .led_left (led_left), .seg_value (seg_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [31:0] a, input logic ld);
    if (!ld)                      return 32'h0;
    if (a < 32'hFFFF_FC00)        return ram_rdata;
    if (a == 32'hFFFF_FC70)       return {24'h0, sw_right};
    if (a == 32'hFFFF_FC72)       return {24'h0, sw_left};
    if (a == 32'hFFFF_FC73)       return {31'h0, btn_enter};
    return 32'h0;
  endfunction

  function automatic string rd_req(input logic [31:0] a, input logic ld);
    if (!ld)                                        return "R8 idle";
    if (a < 32'hFFFF_FC00)                          return "R5";
    if (a == 32'hFFFF_FC70 || a == 32'hFFFF_FC72)   return "R6";
    if (a == 32'hFFFF_FC73)                         return "R7";
    return "R8 unmapped";
  endfunction

  task automatic access(input logic [31:0] a, input logic [31:0] wd,
                        input logic st, input logic ld);
    logic we_exp, lr, ll, sg;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd; cpu_store = st; cpu_load = ld;
    ram_rdata = $urandom; sw_right = 8'($urandom); sw_left = 8'($urandom);
    btn_enter = 1'($urandom);
    #1;
    we_exp = st && (a < 32'hFFFF_FC00);
    lr = st && (a == 32'hFFFF_FC60);
    ll = st && (a == 32'hFFFF_FC62);
    sg = st && (a == 32'hFFFF_FC80);
    chk("R1 ram_we", {31'h0, ram_we}, {31'h0, we_exp});
    chk("R2 strobe", {31'h0, led_wr_right}, {31'h0, lr});
    chk("R3 strobe", {31'h0, led_wr_left}, {31'h0, ll});
    chk("R4 strobe", {31'h0, seg_wr}, {31'h0, sg});
    chk(rd_req(a, ld), cpu_rdata, exp_rdata(a, ld));
    chk("R9 led_right", {24'h0, led_right}, {24'h0, m_ledr});
    chk("R9 led_left", {24'h0, led_left}, {24'h0, m_ledl});
    chk("R9 seg_value", seg_value, m_seg);
    @(posedge clk);
    if (lr) m_ledr = wd[7:0];
    if (ll) m_ledl = wd[7:0];
    if (sg) m_seg = wd;
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 12)
      0: return 32'hFFFF_FC60;
      1: return 32'hFFFF_FC62;
      2: return 32'hFFFF_FC70;
      3: return 32'hFFFF_FC72;
      4: return 32'hFFFF_FC73;
      5: return 32'hFFFF_FC80;
      6: return 32'hFFFF_FC00 + ($urandom % 1024);
      7: return 32'hFFFF_FBFF;
      8: return 32'hFFFF_FC61;
      default: return $urandom % 32'hFFFF_FC00;
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 reset led_right", {24'h0, led_right}, 32'h0);
    chk("R9 reset led_left", {24'h0, led_left}, 32'h0);
    chk("R9 reset seg_value", seg_value, 32'h0);
    rst_n = 1'b1;
    // directed corners
    access(32'hFFFF_FC60, 32'hDEAD_BEA5, 1, 0);   // R2
    access(32'hFFFF_FC62, 32'h1234_5678, 1, 0);   // R3
    access(32'hFFFF_FC80, 32'h0098_9680, 1, 0);   // R4
    access(32'hFFFF_FC61, 32'hFFFF_FFFF, 1, 0);   // R9 neighbour byte
    access(32'hFFFF_FC81, 32'hFFFF_FFFF, 1, 0);   // R9 neighbour byte
    access(32'hFFFF_FC00, 32'hAAAA_AAAA, 1, 0);   // R1 window base
    access(32'hFFFF_FBFF, 32'h5555_5555, 1, 0);   // R1 last RAM byte
    access(32'hFFFF_FBFF, 32'h0, 0, 1);           // R5
    access(32'hFFFF_FC00, 32'h0, 0, 1);           // R8
    access(32'hFFFF_FC60, 32'h0, 0, 1);           // R8 LED not readable
    access(32'hFFFF_FC70, 32'h0, 0, 1);           // R6
    access(32'hFFFF_FC72, 32'h0, 0, 1);           // R6
    access(32'hFFFF_FC73, 32'h0, 0, 1);           // R7
    access(32'hFFFF_FC71, 32'h0, 0, 1);           // R8
    access(32'h0000_0000, 32'h0, 0, 1);           // R5
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      k = 2'($urandom);
      access(pick_addr(), $urandom, k == 2'd1, k == 2'd2);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule